// File: doc/BRIEF.md
# Double-Buffered Serial DAC Register Front End

This block receives 32-bit write frames over a three-wire serial port and turns them into a parallel code for a digital-to-analog converter. The controller pulls a frame-select line low, shifts one bit per falling edge of the serial clock with the most significant bit first, and then releases frame-select. The rising edge of frame-select ends the frame. If exactly 32 bits arrived, the frame is decoded by its top byte as either a data write or a configuration write.

Data writes go into a staging (buffer) register. A mode bit in the configuration word selects how the staged code reaches the output register that drives the converter. In free-running mode the output follows each completed data frame without further action. In strobed mode the output changes only on a falling edge of the load strobe, so a new code can be staged without disturbing the output. All serial and strobe inputs are oversampled by a system clock through a multi-flop synchronizer. Everything inside the block runs on that one clock.

Top module: `dacif_top`

## Requirements
- R1: While reset is asserted and after it is released, the output code and the configuration word read zero, which selects free-running mode.
- R2: A frame is collected one SDIN bit per SCLK falling edge while SYNC_n is low, most significant bit first; bits 31:24 form the address and bits 23:0 the payload.
- R3: The staging register is written only when SYNC_n rises at the end of a frame; LDAC_n activity never moves serial data into it.
- R4: A frame that held a number of SCLK falling edges other than 32 when SYNC_n rises is dropped and changes neither the staging register, the output code nor the configuration word.
- R5: With SYNC_n held low indefinitely, no shifted data reaches the output, even when LDAC_n is pulsed.
- R6: A frame with address 0x02 loads its 24-bit payload into the configuration word; payload bit 14 selects the update mode (0 free-running, 1 strobed).
- R7: In free-running mode a completed data frame updates the output code by itself, and LDAC_n has no effect.
- R8: In strobed mode a data frame leaves the output code unchanged, and the output takes the staged code on the next LDAC_n falling edge.
- R9: A frame with address 0x01 carries the 20-bit code in bits 23:4 (bits 3:0 are ignored); a frame with any other address except 0x02 changes nothing.
- R10: A completed frame shows at the outputs after the fourth rising clk edge, counting from the first edge that samples SYNC_n high; an LDAC_n falling edge acts after the third edge, counting from the first that samples it low.
- R11: SCLK falling edges while SYNC_n is high are not counted toward the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, data taken on its falling edge |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Active-low load strobe, falling edge acts in strobed mode |
| dac_code | output | 20 | Output register driving the converter |
| cfg_word | output | 24 | Configuration word, bit 14 is the update mode |

## Verification
A corrupted bit counter shows up as a valid frame being dropped, or a short frame being accepted. Either is visible on dac_code or cfg_word four clk edges after SYNC_n is sampled high. A wrong mode bit shows up as the output moving on a data frame when it should wait for LDAC_n, or not moving on a strobe. A stale staging register only appears after the next LDAC_n falling edge, three edges after it is sampled. The bench therefore compares both outputs against a behavioural model on every clk cycle, so any of these faults is caught in the cycle it first reaches a port.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

   localparam int FRAME_BITS_D  = 32;
   localparam int ADDR_W_D      = 8;
   localparam int CODE_W_D      = 20;
   localparam int CODE_LSB_D    = 4;
   localparam int MODE_BIT_D    = 14;
   localparam int SYNC_STAGES_D = 2;

   localparam logic [ADDR_W_D-1:0] ADDR_DATA_D = 8'h01;
   localparam logic [ADDR_W_D-1:0] ADDR_CFG_D  = 8'h02;

   typedef enum logic {
      UPD_FREE   = 1'b0,
      UPD_STROBE = 1'b1
   } upd_mode_e;

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
   parameter int                WIDTH   = 4,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("dacif_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("dacif_sync: WIDTH must be positive");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[LAST];

endmodule

// File: rtl/dacif_edges.sv
module dacif_edges #(
   parameter int               WIDTH     = 3,
   parameter logic [WIDTH-1:0] FALL_MASK = '0,
   parameter logic [WIDTH-1:0] RST_VAL   = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] ev
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl;
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      if (FALL_MASK[g]) begin : g_fall
         assign ev[g] = prev_q[g] & ~lvl[g];
      end else begin : g_rise
         assign ev[g] = ~prev_q[g] & lvl[g];
      end
   end

endmodule

// File: rtl/dacif_shifter.sv
module dacif_shifter #(
   parameter int FRAME_BITS = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bit_in,
   input  logic                  sclk_fall,
   input  logic                  selected,
   input  logic                  frame_end,
   output logic                  done_o,
   output logic                  ok_o,
   output logic [FRAME_BITS-1:0] word_o
);

   localparam int CNT_MAX = FRAME_BITS + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_MAX);

   if (FRAME_BITS < 2) begin : g_bad_frame
      $error("dacif_shifter: FRAME_BITS must be at least 2");
   end

   logic [FRAME_BITS-1:0] shreg_q;
   logic [CNT_W-1:0]      cnt_q;
   logic                  done_q;
   logic                  ok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
         ok_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (frame_end) begin
            done_q <= 1'b1;
            ok_q   <= (cnt_q == CNT_FULL);
            cnt_q  <= '0;
         end else if (selected && sclk_fall) begin
            shreg_q <= {shreg_q[FRAME_BITS-2:0], bit_in};
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // The shift register is held while SYNC_n is high, so it is handed out as is.
   assign done_o = done_q;
   assign ok_o   = ok_q;
   assign word_o = shreg_q;

   p_cnt_bound_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_SAT);

   p_done_pulse_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   p_word_frozen_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $stable(shreg_q));

endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
   import dacif_pkg::*;
#(
   parameter int                 FRAME_BITS = 32,
   parameter int                 ADDR_W     = 8,
   parameter int                 CODE_W     = 20,
   parameter int                 CODE_LSB   = 4,
   parameter int                 MODE_BIT   = 14,
   parameter logic [ADDR_W-1:0]  ADDR_DATA  = 8'h01,
   parameter logic [ADDR_W-1:0]  ADDR_CFG   = 8'h02
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             frame_done,
   input  logic                             frame_ok,
   input  logic [FRAME_BITS-1:0]            frame_word,
   input  logic                             ldac_fall,
   output logic [CODE_W-1:0]                code_o,
   output logic [FRAME_BITS-ADDR_W-1:0]     cfg_o
);

   localparam int PAY_W    = FRAME_BITS - ADDR_W;
   localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

   if (ADDR_W < 1 || ADDR_W >= FRAME_BITS) begin : g_bad_addr
      $error("dacif_regs: ADDR_W must leave room for a payload");
   end
   if (CODE_MSB >= PAY_W) begin : g_bad_code
      $error("dacif_regs: code field does not fit in the payload");
   end
   if (MODE_BIT >= PAY_W) begin : g_bad_mode
      $error("dacif_regs: MODE_BIT outside the payload");
   end

   logic [ADDR_W-1:0] addr_w;
   logic [PAY_W-1:0]  payload_w;
   logic [CODE_W-1:0] code_w;
   logic              accept_w;
   logic              wr_data;
   logic              wr_cfg;

   logic [PAY_W-1:0]  cfg_q;
   logic [CODE_W-1:0] buf_q;
   logic [CODE_W-1:0] act_q;
   upd_mode_e         mode;

   assign addr_w    = frame_word[FRAME_BITS-1 -: ADDR_W];
   assign payload_w = frame_word[PAY_W-1:0];
   assign code_w    = frame_word[CODE_MSB:CODE_LSB];
   assign accept_w  = frame_done && frame_ok;
   assign wr_data   = accept_w && (addr_w == ADDR_DATA);
   assign wr_cfg    = accept_w && (addr_w == ADDR_CFG);
   assign mode      = upd_mode_e'(cfg_q[MODE_BIT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         buf_q <= '0;
         act_q <= '0;
      end else begin
         if (wr_cfg)  cfg_q <= payload_w;
         if (wr_data) buf_q <= code_w;
         if (wr_data && mode == UPD_FREE)
            act_q <= code_w;
         else if (ldac_fall && mode == UPD_STROBE)
            act_q <= buf_q;
      end
   end

   assign code_o = act_q;
   assign cfg_o  = cfg_q;

   p_free_follow_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && mode == UPD_FREE) |=> (act_q == $past(code_w)));

   p_strobe_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == UPD_STROBE && !ldac_fall) |=> $stable(act_q));

   p_cfg_load_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_cfg |=> (cfg_q == $past(payload_w)));

   p_drop_bad_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !frame_ok && !ldac_fall) |=> ($stable(act_q) && $stable(cfg_q) && $stable(buf_q)));

   p_free_ldac_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == UPD_FREE && !wr_data) |=> $stable(act_q));

endmodule

// File: rtl/dacif_top.sv
module dacif_top
   import dacif_pkg::*;
#(
   parameter int                FRAME_BITS  = FRAME_BITS_D,
   parameter int                ADDR_W      = ADDR_W_D,
   parameter int                CODE_W      = CODE_W_D,
   parameter int                CODE_LSB    = CODE_LSB_D,
   parameter int                MODE_BIT    = MODE_BIT_D,
   parameter int                SYNC_STAGES = SYNC_STAGES_D,
   parameter logic [ADDR_W-1:0] ADDR_DATA   = ADDR_DATA_D,
   parameter logic [ADDR_W-1:0] ADDR_CFG    = ADDR_CFG_D
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sclk,
   input  logic                         sync_n,
   input  logic                         sdin,
   input  logic                         ldac_n,
   output logic [CODE_W-1:0]            dac_code,
   output logic [FRAME_BITS-ADDR_W-1:0] cfg_word
);

   localparam int PAY_W = FRAME_BITS - ADDR_W;

   // Synchronized vector: [3] sclk, [2] sync_n, [1] sdin, [0] ldac_n
   localparam int          IN_W    = 4;
   localparam logic [3:0]  IN_IDLE = 4'b1101;
   // Edge vector: [2] sclk fall, [1] sync_n rise, [0] ldac_n fall
   localparam int          EV_W    = 3;
   localparam logic [2:0]  EV_FALL = 3'b101;
   localparam logic [2:0]  EV_IDLE = 3'b111;

   logic [IN_W-1:0]       in_s;
   logic [EV_W-1:0]       ev;
   logic                  frame_done;
   logic                  frame_ok;
   logic [FRAME_BITS-1:0] frame_word;

   dacif_sync #(
      .WIDTH   (IN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sclk, sync_n, sdin, ldac_n}),
      .q     (in_s)
   );

   dacif_edges #(
      .WIDTH     (EV_W),
      .FALL_MASK (EV_FALL),
      .RST_VAL   (EV_IDLE)
   ) u_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   ({in_s[3], in_s[2], in_s[0]}),
      .ev    (ev)
   );

   dacif_shifter #(
      .FRAME_BITS (FRAME_BITS)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_in    (in_s[1]),
      .sclk_fall (ev[2]),
      .selected  (~in_s[2]),
      .frame_end (ev[1]),
      .done_o    (frame_done),
      .ok_o      (frame_ok),
      .word_o    (frame_word)
   );

   dacif_regs #(
      .FRAME_BITS (FRAME_BITS),
      .ADDR_W     (ADDR_W),
      .CODE_W     (CODE_W),
      .CODE_LSB   (CODE_LSB),
      .MODE_BIT   (MODE_BIT),
      .ADDR_DATA  (ADDR_DATA),
      .ADDR_CFG   (ADDR_CFG)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_done (frame_done),
      .frame_ok   (frame_ok),
      .frame_word (frame_word),
      .ldac_fall  (ev[0]),
      .code_o     (dac_code),
      .cfg_o      (cfg_word)
   );

   p_hold_low_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!in_s[2] && $past(!in_s[2]) && !cfg_word[MODE_BIT]) |=> $stable(dac_code));

   p_cfg_only_on_frame_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |=> $stable(cfg_word));

   if (PAY_W < 1) begin : g_bad_payload
      $error("dacif_top: empty payload");
   end

endmodule

// File: tb/dacif_top_test.sv
module dacif_top_test;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 4;
   localparam int WD_CYCLES  = 60000;

   logic clk    = 1'b0;
   logic rst_n  = 1'b0;
   logic sclk   = 1'b1;
   logic sync_n = 1'b1;
   logic sdin   = 1'b0;
   logic ldac_n = 1'b1;
   logic [19:0] dac_code;
   logic [23:0] cfg_word;

   always #(CLK_PERIOD/2) clk = ~clk;

   dacif_top uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk     (sclk),
      .sync_n   (sync_n),
      .sdin     (sdin),
      .ldac_n   (ldac_n),
      .dac_code (dac_code),
      .cfg_word (cfg_word)
   );

   int checks = 0;
   int errors = 0;
   bit cmp_en = 1'b0;

   // Behavioural reference: history of sampled pins {sclk,sync_n,sdin,ldac_n}
   logic [3:0]  hist[$];
   logic [3:0]  cur, prv;
   logic [31:0] m_shift;
   int          m_cnt;
   bit          p_valid;
   logic [31:0] p_word;
   logic [23:0] m_cfg;
   logic [19:0] m_buf, m_act;
   bit          old_strobe;

   always @(posedge clk) begin
      if (!rst_n) begin
         hist.delete();
         for (int i = 0; i < 6; i++) hist.push_back(4'b1101);
         m_shift = '0; m_cnt = 0; p_valid = 0; p_word = '0;
         m_cfg = '0; m_buf = '0; m_act = '0;
      end else begin
         hist.push_front({sclk, sync_n, sdin, ldac_n});
         if (hist.size() > 8) void'(hist.pop_back());
         cur = hist[2];
         prv = hist[3];
         old_strobe = m_cfg[14];
         if (p_valid && p_word[31:24] == 8'h01 && !old_strobe)
            m_act = p_word[23:4];
         else if (!cur[0] && prv[0] && old_strobe)
            m_act = m_buf;
         if (p_valid && p_word[31:24] == 8'h01) m_buf = p_word[23:4];
         if (p_valid && p_word[31:24] == 8'h02) m_cfg = p_word[23:0];
         p_valid = 0;
         if (cur[2] && !prv[2]) begin
            if (m_cnt == 32) begin p_valid = 1; p_word = m_shift; end
            m_cnt = 0;
         end else if (!cur[2] && !cur[3] && prv[3]) begin
            m_shift = {m_shift[30:0], cur[1]};
            if (m_cnt < 33) m_cnt++;
         end
      end
   end

   // R10: cycle-exact comparison of both outputs against the reference
   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         checks++;
         if (dac_code !== m_act) begin
            errors++;
            $display("FAIL R10 cycle dac_code actual %h expected %h at %0t", dac_code, m_act, $time);
         end
         checks++;
         if (cfg_word !== m_cfg) begin
            errors++;
            $display("FAIL R10 cycle cfg_word actual %h expected %h at %0t", cfg_word, m_cfg, $time);
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [31:0] w, input int n, input bit raise);
      sync_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < n; i++) begin
         sdin = (i < 32) ? w[31-i] : 1'b0;
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
         wait_clk(HALF);
      end
      sclk = 1'b1;
      wait_clk(HALF);
      if (raise) sync_n = 1'b1;
      wait_clk(10);
   endtask

   task automatic pulse_ldac();
      ldac_n = 1'b0;
      wait_clk(6);
      ldac_n = 1'b1;
      wait_clk(6);
   endtask

   function automatic logic [31:0] data_word(input logic [19:0] code);
      return {8'h01, code, 4'h5};
   endfunction

   initial begin
      wait_clk(5);
      check("R1 reset code", {12'h0, dac_code}, 32'h0);
      check("R1 reset cfg", {8'h0, cfg_word}, 32'h0);
      rst_n = 1'b1;
      cmp_en = 1'b1;
      wait_clk(5);
      check("R1 after release code", {12'h0, dac_code}, 32'h0);

      // R2 R7 R9: free-running data write, low nibble ignored
      send_bits(data_word(20'hABCDE), 32, 1);
      check("R2 R7 R9 free data write", {12'h0, dac_code}, 32'h000ABCDE);

      // R4: short and long frames dropped
      send_bits(data_word(20'h11111), 31, 1);
      check("R4 31-bit frame dropped", {12'h0, dac_code}, 32'h000ABCDE);
      send_bits(data_word(20'h22222), 33, 1);
      check("R4 33-bit frame dropped", {12'h0, dac_code}, 32'h000ABCDE);
      check("R4 cfg untouched", {8'h0, cfg_word}, 32'h0);

      // R9: unknown address
      send_bits({8'h05, 24'hFFFFFF}, 32, 1);
      check("R9 unknown addr code", {12'h0, dac_code}, 32'h000ABCDE);
      check("R9 unknown addr cfg", {8'h0, cfg_word}, 32'h0);

      // R11: SCLK falls with SYNC_n high do not count
      for (int i = 0; i < 3; i++) begin
         sclk = 1'b0; wait_clk(HALF);
         sclk = 1'b1; wait_clk(HALF);
      end
      send_bits(data_word(20'h55AA3), 32, 1);
      check("R11 idle clocks ignored", {12'h0, dac_code}, 32'h00055AA3);

      // R7: LDAC ignored in free-running mode
      pulse_ldac();
      check("R7 ldac ignored", {12'h0, dac_code}, 32'h00055AA3);

      // R6: switch to strobed mode
      send_bits({8'h02, 24'h004000}, 32, 1);
      check("R6 cfg written", {8'h0, cfg_word}, 32'h00004000);

      // R8: staged, then strobed
      send_bits(data_word(20'h12345), 32, 1);
      check("R8 output held", {12'h0, dac_code}, 32'h00055AA3);
      pulse_ldac();
      check("R8 ldac moves code", {12'h0, dac_code}, 32'h00012345);

      // R5: SYNC_n stays low, LDAC pulsed
      send_bits(data_word(20'h0F0F0), 32, 0);
      pulse_ldac();
      check("R5 held-low no transfer", {12'h0, dac_code}, 32'h00012345);
      sync_n = 1'b1;
      wait_clk(10);
      check("R3 rise stages only", {12'h0, dac_code}, 32'h00012345);
      pulse_ldac();
      check("R3 staged on rise", {12'h0, dac_code}, 32'h000F0F0);

      // R6 R7: back to free-running
      send_bits({8'h02, 24'h000000}, 32, 1);
      check("R6 mode cleared", {8'h0, cfg_word}, 32'h0);
      send_bits(data_word(20'hFEDCB), 32, 1);
      check("R7 free again", {12'h0, dac_code}, 32'h000FEDCB);

      // R1: reset mid-operation
      cmp_en = 1'b0;
      rst_n = 1'b0;
      wait_clk(3);
      check("R1 reset again code", {12'h0, dac_code}, 32'h0);
      check("R1 reset again cfg", {8'h0, cfg_word}, 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R10 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule